// File: doc/BRIEF.md
# GPIO Bank with Interrupt Summary

This block is a bank of general-purpose pins behind a simple word-addressed register port. For each pin, software sets whether the pin drives and what value it drives, and reads back the pin's level after synchronisation. Each pin also has its own interrupt controls. Detection is by level or by a single edge, with a chosen polarity. A sticky status bit is cleared by writing one to it. Two further controls gate the status latch and interrupt delivery separately. A three-bit routing code names the processor that is to receive the pin's interrupt.

Every pin that is delivering an interrupt feeds one shared summary output. Delivery and status recording are gated separately. A pin can therefore raise the summary line while its status bit stays clear. A pin can also record status without raising the line. The hardware detects one edge direction only. Software that needs both edges must flip the polarity after each event.

Each pin has a block of four words starting at 0x1000 + 0x10·n:
- control at +0x0
- level and drive at +0x4
- interrupt setup at +0x8
- status at +0xC

Each pin's routing word is at 0x400 + 0x4·n. Reads of the register port are combinational. Writes take effect at the next rising clock edge.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq_summary` is low.
- R2: Bit 9 of a pin's control word (+0x0) drives `pin_oe[n]` and reads back. Bit 1 of the level/drive word (+0x4) drives `pin_out[n]` and reads back. The other bits of these words read zero.
- R3: Bit 0 of the level/drive word returns the pin level through a two-flop synchroniser. A change that is present before a rising edge is visible after the second rising edge.
- R4: The interrupt-setup word (+0x8) holds four bits, and all four read back: bit 0 delivery enable, bit 1 polarity (1 = rising/high), bit 2 mode (1 = edge, 0 = level) and bit 3 status-record enable. In level mode a pin is triggered for as long as its synchronised level equals the polarity.
- R5: In edge mode only the edge selected by the polarity triggers. A rising edge triggers when the polarity is 1 and a falling edge when it is 0. A steady level never triggers.
- R6: Status bit 0 (+0xC) is set by a trigger when record is enabled and then stays set. Writing 1 to it clears it, and writing 0 has no effect. A clear wins over a trigger in the same cycle. A level-mode pin whose level is still active reads 1 again one cycle after the clear.
- R7: With status-record enable at 0, a trigger leaves the status bit clear. With delivery enabled, the summary output still follows the trigger.
- R8: `irq_summary` is high while any pin has delivery enabled, a routing code other than 7, and either its status bit set or a trigger present. Clearing delivery enable removes that pin's contribution.
- R9: The routing word (0x400 + 0x4·n) holds a 3-bit code that reads back. Code 7 means no processor and blocks the pin from the summary output, while the status bit is still recorded. Code 4 names the application processor.
- R10: Reads of unmapped offsets return zero. This covers pin indices at or above the pin count, addresses that are not word-aligned, and any address outside the two regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wen | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Value driven on each pin |
| pin_oe | output | NPINS | Output enable for each pin |
| irq_summary | output | 1 | OR of all delivering pin interrupts |

## Verification
The synchroniser check requires `pin_in` to be a settled value at each rising edge. The edge-mode check requires the stored previous level to be that same synchronised history. The bench therefore changes pins only at falling edges and holds each level for at least three cycles before checking status. Register writes are issued one per cycle from a falling edge and are word-aligned unless an unmapped access is being tested. The status checks therefore see a single, well-defined clear cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef struct packed {
        logic rec_en;   // bit 3: record status
        logic edge_md;  // bit 2: 1 = edge, 0 = level
        logic pol;      // bit 1: 1 = rising/high
        logic dlv_en;   // bit 0: deliver to summary
    } irq_cfg_t;

    localparam int          OE_BIT     = 9;
    localparam int          DRV_BIT    = 1;
    localparam int          ROUTE_W    = 3;
    localparam logic [2:0]  ROUTE_NONE = 3'd7;
    localparam logic [2:0]  ROUTE_APP  = 3'd4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.s2;
    assign lvl_prev = st_q.s3;

    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (lvl == $past(pin_in, 2)));

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_bank_pkg::*;
#(
    parameter int RW = ROUTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl,
    input  logic          lvl_prev,
    input  irq_cfg_t      cfg,
    input  logic [RW-1:0] route,
    input  logic          clr,
    output logic          stat,
    output logic          deliver
);
    typedef struct packed {
        logic stat;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    trig;

    always_comb begin
        if (cfg.edge_md)
            trig = cfg.pol ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);
        else
            trig = (lvl == cfg.pol);

        st_d = st_q;
        if (clr)
            st_d.stat = 1'b0;
        else if (cfg.rec_en && trig)
            st_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat    = st_q.stat;
    assign deliver = cfg.dlv_en && (route != RW'(ROUTE_NONE)) && (st_q.stat || trig);

    // R7
    no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.rec_en && !st_q.stat) |=> !st_q.stat);

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.stat);

    // R5
    steady_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.edge_md && (lvl == lvl_prev) && !st_q.stat) |=> !st_q.stat);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_summary
);
    localparam logic [ADDR_W-1:0] PIN_BASE   = ADDR_W'(16'h1000);
    localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'(16'h0400);
    localparam logic [ADDR_W-1:0] NPINS_A    = ADDR_W'(NPINS);

    typedef struct packed {
        logic [NPINS-1:0]              oe;
        logic [NPINS-1:0]              drv;
        irq_cfg_t [NPINS-1:0]          icfg;
        logic [NPINS-1:0][ROUTE_W-1:0] route;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] poff, roff;
    logic              pin_hit, route_hit;
    logic [NPINS-1:0]  hit_ctl, hit_drv, hit_icfg, hit_stat, hit_route;
    logic [NPINS-1:0]  clr, stat, deliver, lvl, lvl_prev;

    // address decode
    always_comb begin
        poff      = bus_addr - PIN_BASE;
        roff      = bus_addr - ROUTE_BASE;
        pin_hit   = (bus_addr >= PIN_BASE) && ((poff >> 4) < NPINS_A)
                    && (bus_addr[1:0] == 2'b00);
        route_hit = (bus_addr >= ROUTE_BASE) && (bus_addr < PIN_BASE)
                    && ((roff >> 2) < NPINS_A) && (bus_addr[1:0] == 2'b00);
        for (int i = 0; i < NPINS; i++) begin
            hit_ctl[i]   = pin_hit && ((poff >> 4) == ADDR_W'(i)) && (poff[3:2] == 2'd0);
            hit_drv[i]   = pin_hit && ((poff >> 4) == ADDR_W'(i)) && (poff[3:2] == 2'd1);
            hit_icfg[i]  = pin_hit && ((poff >> 4) == ADDR_W'(i)) && (poff[3:2] == 2'd2);
            hit_stat[i]  = pin_hit && ((poff >> 4) == ADDR_W'(i)) && (poff[3:2] == 2'd3);
            hit_route[i] = route_hit && ((roff >> 2) == ADDR_W'(i));
        end
    end

    // register writes and W1C strobes
    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_wen) begin
                if (hit_ctl[i])   regs_d.oe[i]    = bus_wdata[OE_BIT];
                if (hit_drv[i])   regs_d.drv[i]   = bus_wdata[DRV_BIT];
                if (hit_icfg[i])  regs_d.icfg[i]  = irq_cfg_t'(bus_wdata[3:0]);
                if (hit_route[i]) regs_d.route[i] = bus_wdata[ROUTE_W-1:0];
                clr[i] = hit_stat[i] && bus_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (hit_ctl[i])   bus_rdata[OE_BIT]  = regs_q.oe[i];
            if (hit_drv[i])   bus_rdata[1:0]     = {regs_q.drv[i], lvl[i]};
            if (hit_icfg[i])  bus_rdata[3:0]     = regs_q.icfg[i];
            if (hit_stat[i])  bus_rdata[0]       = stat[i];
            if (hit_route[i]) bus_rdata[ROUTE_W-1:0] = regs_q.route[i];
        end
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_irq #(.RW(ROUTE_W)) u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[g]),
            .lvl_prev (lvl_prev[g]),
            .cfg      (regs_q.icfg[g]),
            .route    (regs_q.route[g]),
            .clr      (clr[g]),
            .stat     (stat[g]),
            .deliver  (deliver[g])
        );

        // R2
        oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wen && hit_ctl[g]) |=> (pin_oe[g] == $past(bus_wdata[OE_BIT])));
    end

    assign pin_oe      = regs_q.oe;
    assign pin_out     = regs_q.drv;
    assign irq_summary = |deliver;

endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    localparam int NP = 8;
    localparam int AW = 13;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [31:0]   exp;
    } vec_t;

    // register write/readback vectors (R2, R4, R9, R10)
    localparam vec_t VECS [15] = '{
        '{13'h1050, 32'hFFFF_FFFF, 32'h0000_0200},
        '{13'h1054, 32'h0000_0002, 32'h0000_0002},
        '{13'h1068, 32'h0000_0006, 32'h0000_0006},
        '{13'h1078, 32'h0000_00F4, 32'h0000_0004},
        '{13'h0414, 32'h0000_00FF, 32'h0000_0007},
        '{13'h0418, 32'h0000_0004, 32'h0000_0004},
        '{13'h1080, 32'h0000_0200, 32'h0000_0000},
        '{13'h0420, 32'h0000_0007, 32'h0000_0000},
        '{13'h1051, 32'h0000_0200, 32'h0000_0000},
        '{13'h1050, 32'h0000_0000, 32'h0000_0000},
        '{13'h1054, 32'h0000_0000, 32'h0000_0000},
        '{13'h1068, 32'h0000_0000, 32'h0000_0000},
        '{13'h1078, 32'h0000_0000, 32'h0000_0000},
        '{13'h0414, 32'h0000_0000, 32'h0000_0000},
        '{13'h0418, 32'h0000_0000, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wen = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_summary;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(NP), .ADDR_W(AW)) u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_summary(irq_summary)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] pa(input int pin, input int w);
        return AW'(32'h1000 + 16 * pin + 4 * w);
    endfunction

    function automatic logic [AW-1:0] ra(input int pin);
        return AW'(32'h400 + 4 * pin);
    endfunction

    initial begin : watchdog
        #400000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        cyc(3);
        // R1 reset state
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 out", 32'(pin_out), 0);
        chk("R1 summary", 32'(irq_summary), 0);
        rst_n = 1'b1;
        cyc(1);
        rd(pa(2, 0), r); chk("R1 ctl", r, 0);
        rd(pa(2, 2), r); chk("R1 icfg", r, 0);
        rd(pa(2, 3), r); chk("R1 stat", r, 0);
        rd(ra(2), r);    chk("R1 route", r, 0);
        chk("R1 summary after release", 32'(irq_summary), 0);

        // table of write/readback vectors
        for (int v = 0; v < 15; v++) begin
            wr(VECS[v].addr, VECS[v].wdata);
            rd(VECS[v].addr, r);
            chk("R2/R4/R9/R10 vector", r, VECS[v].exp);
        end

        // R2 pin ports
        wr(pa(0, 0), 32'h200);
        wr(pa(0, 1), 32'h2);
        chk("R2 oe port", 32'(pin_oe), 32'h1);
        chk("R2 out port", 32'(pin_out), 32'h1);
        wr(pa(0, 0), 32'h0);
        chk("R2 oe cleared", 32'(pin_oe), 0);

        // R3 synchroniser latency
        pin_in[0] = 1'b1;
        cyc(1); rd(pa(0, 1), r); chk("R3 one edge", r, 32'h2);
        cyc(1); rd(pa(0, 1), r); chk("R3 two edges", r, 32'h3);
        wr(pa(0, 1), 32'h0);
        pin_in[0] = 1'b0;
        cyc(3);

        // R4/R6 level mode on pin1
        wr(ra(1), 32'h4);
        wr(pa(1, 2), 32'hB);
        pin_in[1] = 1'b1;
        cyc(2); chk("R4 level summary", 32'(irq_summary), 1);
        cyc(1); rd(pa(1, 3), r); chk("R4 level status", r, 1);
        wr(pa(1, 3), 32'h1);
        rd(pa(1, 3), r); chk("R6 clear wins", r, 0);
        cyc(1); rd(pa(1, 3), r); chk("R6 level reasserts", r, 1);
        wr(pa(1, 3), 32'h0);
        rd(pa(1, 3), r); chk("R6 write zero ignored", r, 1);
        pin_in[1] = 1'b0;
        cyc(3); rd(pa(1, 3), r); chk("R6 sticky", r, 1);
        chk("R8 status keeps summary", 32'(irq_summary), 1);
        wr(pa(1, 3), 32'h1);
        cyc(1);
        rd(pa(1, 3), r); chk("R6 cleared", r, 0);
        chk("R8 summary drops", 32'(irq_summary), 0);
        wr(pa(1, 2), 32'h0);

        // R5 edge mode on pin2
        wr(ra(2), 32'h4);
        wr(pa(2, 2), 32'hF);
        pin_in[2] = 1'b1;
        cyc(3); rd(pa(2, 3), r); chk("R5 rising caught", r, 1);
        wr(pa(2, 3), 32'h1);
        cyc(2); rd(pa(2, 3), r); chk("R5 steady high", r, 0);
        pin_in[2] = 1'b0;
        cyc(3); rd(pa(2, 3), r); chk("R5 falling ignored", r, 0);
        wr(pa(2, 2), 32'hD);
        pin_in[2] = 1'b1;
        cyc(3); rd(pa(2, 3), r); chk("R5 rising ignored", r, 0);
        pin_in[2] = 1'b0;
        cyc(3); rd(pa(2, 3), r); chk("R5 falling caught", r, 1);
        wr(pa(2, 3), 32'h1);
        wr(pa(2, 2), 32'h0);
        chk("R8 idle before raw test", 32'(irq_summary), 0);

        // R7 record disabled, rising edge on pin3
        wr(ra(3), 32'h4);
        wr(pa(3, 2), 32'h7);
        pin_in[3] = 1'b1;
        cyc(1); chk("R7 not yet", 32'(irq_summary), 0);
        cyc(1); chk("R7 pulse", 32'(irq_summary), 1);
        cyc(1); chk("R7 pulse ends", 32'(irq_summary), 0);
        rd(pa(3, 3), r); chk("R7 status clear", r, 0);
        wr(pa(3, 2), 32'h0);

        // R9/R8 routing and delivery on pin4
        wr(ra(4), 32'h7);
        wr(pa(4, 2), 32'hB);
        pin_in[4] = 1'b1;
        cyc(3);
        rd(pa(4, 3), r); chk("R9 status with no route", r, 1);
        chk("R9 no route blocks", 32'(irq_summary), 0);
        wr(ra(4), 32'h4);
        chk("R9 route app", 32'(irq_summary), 1);
        wr(pa(4, 2), 32'hA);
        chk("R8 delivery off", 32'(irq_summary), 0);
        rd(pa(4, 3), r); chk("R8 status kept", r, 1);

        // R10 unmapped
        rd(13'h0000, r); chk("R10 low addr", r, 0);
        rd(13'h1084, r); chk("R10 pin8 word", r, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule